// File: doc/BRIEF.md
# Packed SIMD Immediate-Operand ALU

This block runs one 128-bit packed vector operation per input cycle, where the second operand is a small constant taken from the 32-bit instruction word. It supports wrapping add and subtract, signed and unsigned maximum and minimum, equality, and signed and unsigned less-than and less-or-equal compares. It also supports a load-immediate that broadcasts a constant into every lane. A two-bit format field splits the vector into sixteen 8-bit, eight 16-bit, four 32-bit or two 64-bit lanes.

The surrounding pipeline supplies the instruction word together with the value already read from the source register. One cycle later, the block returns the destination register index and the lane-wise result with a valid strobe. If the instruction is not recognised, the block raises a reserved-instruction flag instead, and no result is produced.

Top module: `simd_imm_alu`

## Requirements
- R1: Instruction bits 22:21 select the lane format: 0 gives 8-bit lanes, 1 gives 16-bit, 2 gives 32-bit and 3 gives 64-bit. Bits 10:6 (the destination index) appear on `out_dst` together with the result.
- R2: When bits 5:0 equal 6'h06, bits 25:23 select the operation: 0 add, 1 subtract, 2 signed max, 3 unsigned max, 4 signed min, 5 unsigned min. When bits 5:0 equal 6'h07, bits 25:23 select: 0 equal, 2 signed less-than, 3 unsigned less-than, 4 signed less-or-equal, 5 unsigned less-or-equal, 6 load-immediate.
- R3: Any other bits 5:0 value, codes 6 and 7 under 6'h06, and codes 1 and 7 under 6'h07 are reserved. For these, `out_rsvd` is high for one cycle, `out_valid` stays low, and `out_vec` and `out_dst` keep their previous values.
- R4: Add and subtract use the 5-bit field at bits 20:16, zero-extended to 0..31. The result wraps modulo the lane width.
- R5: Signed max and min compare each lane, read as two's complement, against bits 20:16 sign-extended to -16..15. They return the chosen operand truncated to the lane width.
- R6: Unsigned max and min compare each lane, read as an unsigned value, against bits 20:16 zero-extended. They return the chosen operand.
- R7: Every compare writes all ones to a lane when the relation holds and all zeros when it does not. Equal, signed less-than and signed less-or-equal use the sign-extended immediate and signed lanes.
- R8: Unsigned less-than and less-or-equal compare unsigned lanes against the zero-extended immediate. This includes 64-bit lanes whose top bit is set.
- R9: Load-immediate sign-extends the 10-bit field at bits 20:11, truncates it to the lane width, and writes it to every lane. The source vector has no effect on the result.
- R10: A result and `out_valid` appear exactly one cycle after a recognised input with `in_valid` high. Without `in_valid`, neither `out_valid` nor `out_rsvd` rises and `out_vec` holds its value.
- R11: A synchronous active-high reset clears `out_valid`, `out_rsvd`, `out_vec` and `out_dst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and source vector are present |
| instr | input | 32 | Instruction word |
| src_vec | input | 128 | Value of the source vector register |
| out_valid | output | 1 | Result strobe, one cycle after the input |
| out_dst | output | 5 | Destination register index |
| out_vec | output | 128 | Lane-wise result |
| out_rsvd | output | 1 | Reserved-instruction flag |

## Verification
Every output is registered once, so a fault in decode or in lane execution shows up on `out_vec` in the cycle right after the input that triggered it. A wrong immediate extension shows up only at the range edges: 31 versus -1, 15 versus -16, and -512 or 511 truncated into narrow lanes. The stimulus therefore concentrates on those values at each of the four formats. A reserved decode that is mistaken for a valid one changes `out_vec` or `out_dst` one cycle later, where a held value was expected.

// File: rtl/simd_imm_pkg.sv
package simd_imm_pkg;

   localparam int LANE_MAX = 64;
   localparam int NUM_FMT  = 4;

   typedef enum logic [3:0] {
      OP_ADD, OP_SUB, OP_MAXS, OP_MAXU, OP_MINS, OP_MINU,
      OP_CEQ, OP_CLTS, OP_CLTU, OP_CLES, OP_CLEU, OP_LDI, OP_NONE
   } op_e;

   localparam logic [5:0] MINOR_ARITH = 6'h06;
   localparam logic [5:0] MINOR_CMP   = 6'h07;

   // indexed by instruction bits 25:23
   localparam op_e ARITH_MAP [8] = '{OP_ADD, OP_SUB, OP_MAXS, OP_MAXU,
                                     OP_MINS, OP_MINU, OP_NONE, OP_NONE};
   localparam op_e CMP_MAP   [8] = '{OP_CEQ, OP_NONE, OP_CLTS, OP_CLTU,
                                     OP_CLES, OP_CLEU, OP_LDI, OP_NONE};

endpackage

// File: rtl/simd_imm_dec.sv
module simd_imm_dec
   import simd_imm_pkg::*;
(
   input  logic [31:0]         instr,
   output op_e                 op,
   output logic [1:0]          df,
   output logic [LANE_MAX-1:0] imm5_x,
   output logic [LANE_MAX-1:0] imm10_x,
   output logic [4:0]          dst,
   output logic                rsvd
);

   logic [2:0] code;
   logic [5:0] minor;
   logic       sext;
   logic       unused_major;

   assign code         = instr[25:23];
   assign minor        = instr[5:0];
   assign df           = instr[22:21];
   assign dst          = instr[10:6];
   assign unused_major = ^instr[31:26];

   always_comb begin
      if (minor == MINOR_ARITH)
         op = ARITH_MAP[code];
      else if (minor == MINOR_CMP)
         op = CMP_MAP[code];
      else
         op = OP_NONE;
   end

   assign rsvd = (op == OP_NONE);
   assign sext = (op == OP_MAXS) || (op == OP_MINS) || (op == OP_CEQ) ||
                 (op == OP_CLTS) || (op == OP_CLES);

   assign imm5_x  = sext ? {{(LANE_MAX-5){instr[20]}}, instr[20:16]}
                         : {{(LANE_MAX-5){1'b0}}, instr[20:16]};
   assign imm10_x = {{(LANE_MAX-10){instr[20]}}, instr[20:11]};

endmodule

// File: rtl/simd_imm_lane.sv
module simd_imm_lane
   import simd_imm_pkg::*;
#(
   parameter int LW = 8
) (
   input  op_e           op,
   input  logic [LW-1:0] a,
   input  logic [LW-1:0] b,
   input  logic [LW-1:0] ld,
   output logic [LW-1:0] y
);

   if (LW < 8 || LW > LANE_MAX) begin : g_bad_lw
      $error("simd_imm_lane: LW out of range");
   end

   logic s_lt, u_lt, eq;

   assign s_lt = $signed(a) < $signed(b);
   assign u_lt = a < b;
   assign eq   = a == b;

   always_comb begin
      case (op)
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_MAXS: y = (s_lt || eq) ? b : a;
         OP_MAXU: y = (u_lt || eq) ? b : a;
         OP_MINS: y = s_lt ? a : b;
         OP_MINU: y = u_lt ? a : b;
         OP_CEQ:  y = {LW{eq}};
         OP_CLTS: y = {LW{s_lt}};
         OP_CLTU: y = {LW{u_lt}};
         OP_CLES: y = {LW{s_lt | eq}};
         OP_CLEU: y = {LW{u_lt | eq}};
         OP_LDI:  y = ld;
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/simd_imm_alu.sv
module simd_imm_alu
   import simd_imm_pkg::*;
#(
   parameter int VEC_W = 128
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [31:0]      instr,
   input  logic [VEC_W-1:0] src_vec,
   output logic             out_valid,
   output logic [4:0]       out_dst,
   output logic [VEC_W-1:0] out_vec,
   output logic             out_rsvd
);

   if (VEC_W < LANE_MAX || (VEC_W % LANE_MAX) != 0) begin : g_bad_width
      $error("simd_imm_alu: VEC_W must be a multiple of LANE_MAX");
   end

   op_e                 op;
   logic [1:0]          df;
   logic [LANE_MAX-1:0] imm5_x;
   logic [LANE_MAX-1:0] imm10_x;
   logic [4:0]          dst;
   logic                rsvd;
   logic [VEC_W-1:0]    fmt_res [NUM_FMT];

   simd_imm_dec u_dec (
      .instr  (instr),
      .op     (op),
      .df     (df),
      .imm5_x (imm5_x),
      .imm10_x(imm10_x),
      .dst    (dst),
      .rsvd   (rsvd)
   );

   for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
      localparam int LW = 8 << g;
      localparam int NL = VEC_W / LW;
      for (genvar l = 0; l < NL; l++) begin : g_lane
         simd_imm_lane #(.LW(LW)) u_lane (
            .op(op),
            .a (src_vec[l*LW +: LW]),
            .b (imm5_x[LW-1:0]),
            .ld(imm10_x[LW-1:0]),
            .y (fmt_res[g][l*LW +: LW])
         );
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_rsvd  <= 1'b0;
         out_vec   <= '0;
         out_dst   <= '0;
      end else begin
         out_valid <= in_valid & ~rsvd;
         out_rsvd  <= in_valid & rsvd;
         if (in_valid && !rsvd) begin
            out_vec <= fmt_res[df];
            out_dst <= dst;
         end
      end
   end

endmodule

// File: rtl/simd_imm_chk.sv
module simd_imm_chk
   import simd_imm_pkg::*;
#(
   parameter int VEC_W = 128
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic [31:0]      instr,
   input logic             out_valid,
   input logic [4:0]       out_dst,
   input logic [VEC_W-1:0] out_vec,
   input logic             out_rsvd
);

   // R3
   excl_flags_chk: assert property (@(posedge clk) disable iff (rst)
      !(out_valid && out_rsvd));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && !out_rsvd && $stable(out_vec)));

   // R10
   respond_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (out_valid || out_rsvd));

   // R1
   dst_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (out_rsvd || out_dst == $past(instr[10:6])));

   // R9
   ldi_bcast_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && instr[5:0] == MINOR_CMP && instr[25:23] == 3'd6)
      |=> (out_vec[VEC_W-1:VEC_W/2] == out_vec[VEC_W/2-1:0]));

   // R3
   rsvd_hold_chk: assert property (@(posedge clk) disable iff (rst)
      out_rsvd |-> ($stable(out_vec) && $stable(out_dst)));

endmodule

bind simd_imm_alu simd_imm_chk #(.VEC_W(VEC_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .instr    (instr),
   .out_valid(out_valid),
   .out_dst  (out_dst),
   .out_vec  (out_vec),
   .out_rsvd (out_rsvd)
);

// File: tb/test_simd_imm_alu.sv
`timescale 1ns/1ps
module test_simd_imm_alu;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [31:0]  instr = '0;
   logic [127:0] src_vec = '0;
   logic         out_valid;
   logic [4:0]   out_dst;
   logic [127:0] out_vec;
   logic         out_rsvd;

   int total = 0;
   int bad = 0;
   logic [127:0] last_vec = '0;
   logic [4:0]   last_dst = '0;

   always #5 clk = ~clk;

   simd_imm_alu i_simd_imm_alu (
      .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
      .src_vec(src_vec), .out_valid(out_valid), .out_dst(out_dst),
      .out_vec(out_vec), .out_rsvd(out_rsvd)
   );

   function automatic logic [31:0] mk(input logic [5:0] minor, input logic [2:0] code,
                                      input logic [1:0] df, input logic [4:0] imm,
                                      input logic [4:0] ws, input logic [4:0] wd);
      return {6'h1E, code, df, imm, ws, wd, minor};
   endfunction

   // returns {reserved, vector}
   function automatic logic [128:0] model(input logic [31:0] ins, input logic [127:0] src);
      int kind, w, n;
      logic [63:0] mask, a, ia, r, s10u;
      longint sa, si;
      logic [127:0] res;
      kind = -1;
      if (ins[5:0] == 6'h06 && ins[25:23] <= 3'd5) kind = int'(ins[25:23]);
      if (ins[5:0] == 6'h07) begin
         case (ins[25:23])
            3'd0: kind = 6;
            3'd2: kind = 7;
            3'd3: kind = 8;
            3'd4: kind = 9;
            3'd5: kind = 10;
            3'd6: kind = 11;
            default: kind = -1;
         endcase
      end
      if (kind < 0) return {1'b1, 128'b0};
      w = 8 << ins[22:21];
      n = 128 / w;
      mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
      if (kind == 2 || kind == 4 || kind == 6 || kind == 7 || kind == 9)
         si = longint'($signed({{59{ins[20]}}, ins[20:16]}));
      else
         si = longint'({59'b0, ins[20:16]});
      ia = 64'(si) & mask;
      s10u = {{54{ins[20]}}, ins[20:11]};
      res = '0;
      for (int i = 0; i < n; i++) begin
         a = 64'(src >> (i * w)) & mask;
         sa = longint'(a << (64 - w)) >>> (64 - w);
         case (kind)
            0: r = (a + ia) & mask;
            1: r = (a - ia) & mask;
            2: r = (sa > si) ? a : ia;
            3: r = (a > ia) ? a : ia;
            4: r = (sa < si) ? a : ia;
            5: r = (a < ia) ? a : ia;
            6: r = (a == ia) ? mask : 64'd0;
            7: r = (sa < si) ? mask : 64'd0;
            8: r = (a < ia) ? mask : 64'd0;
            9: r = (sa <= si) ? mask : 64'd0;
            10: r = (a <= ia) ? mask : 64'd0;
            default: r = s10u & mask;
         endcase
         res = res | ({64'b0, r} << (i * w));
      end
      return {1'b0, res};
   endfunction

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input string tag, input logic [31:0] ins, input logic [127:0] src);
      logic [128:0] e;
      e = model(ins, src);
      @(negedge clk);
      in_valid = 1'b1;
      instr = ins;
      src_vec = src;
      @(negedge clk);
      in_valid = 1'b0;
      if (e[128]) begin
         check({tag, " R3 rsvd"}, 128'(out_rsvd), 128'd1);
         check({tag, " R3 valid"}, 128'(out_valid), 128'd0);
         check({tag, " R3 vec"}, out_vec, last_vec);
         check({tag, " R3 dst"}, 128'(out_dst), 128'(last_dst));
      end else begin
         check({tag, " R10 valid"}, 128'(out_valid), 128'd1);
         check({tag, " R3 rsvd"}, 128'(out_rsvd), 128'd0);
         check({tag, " vec"}, out_vec, e[127:0]);
         check({tag, " R1 dst"}, 128'(out_dst), 128'(ins[10:6]));
         last_vec = e[127:0];
         last_dst = ins[10:6];
      end
   endtask

   localparam logic [127:0] PAT_A = 128'h807F_FF00_0110_1F20_8000_7FFF_FFFF_FFF0;
   localparam logic [127:0] PAT_B = {64'h8000_0000_0000_0000, 64'h0000_0000_0000_001F};
   localparam logic [127:0] PAT_C = 128'hFFFF_FFFF_FFFF_FFFF_0000_0000_0000_0000;

   task automatic t_reset();
      check("R11 valid", 128'(out_valid), 128'd0);
      check("R11 rsvd", 128'(out_rsvd), 128'd0);
      check("R11 vec", out_vec, 128'd0);
      check("R11 dst", 128'(out_dst), 128'd0);
   endtask

   task automatic t_addsub();
      for (int df = 0; df < 4; df++) begin
         issue("R4 add31", mk(6'h06, 3'd0, 2'(df), 5'd31, 5'd1, 5'd2), PAT_C);
         issue("R4 add0",  mk(6'h06, 3'd0, 2'(df), 5'd0, 5'd1, 5'd3), PAT_A);
         issue("R4 sub31", mk(6'h06, 3'd1, 2'(df), 5'd31, 5'd1, 5'd4), PAT_C);
         issue("R4 sub1",  mk(6'h06, 3'd1, 2'(df), 5'd1, 5'd1, 5'd5), PAT_A);
      end
   endtask

   task automatic t_minmax();
      for (int df = 0; df < 4; df++) begin
         issue("R5 maxs15", mk(6'h06, 3'd2, 2'(df), 5'h0F, 5'd0, 5'd6), PAT_A);
         issue("R5 maxs-16", mk(6'h06, 3'd2, 2'(df), 5'h10, 5'd0, 5'd7), PAT_A);
         issue("R5 mins-16", mk(6'h06, 3'd4, 2'(df), 5'h10, 5'd0, 5'd8), PAT_A);
         issue("R5 mins15", mk(6'h06, 3'd4, 2'(df), 5'h0F, 5'd0, 5'd9), PAT_C);
         issue("R6 maxu31", mk(6'h06, 3'd3, 2'(df), 5'd31, 5'd0, 5'd10), PAT_A);
         issue("R6 minu31", mk(6'h06, 3'd5, 2'(df), 5'd31, 5'd0, 5'd11), PAT_B);
         issue("R6 minu0",  mk(6'h06, 3'd5, 2'(df), 5'd0, 5'd0, 5'd12), PAT_C);
      end
   endtask

   task automatic t_compare();
      for (int df = 0; df < 4; df++) begin
         issue("R7 ceq-1",   mk(6'h07, 3'd0, 2'(df), 5'h1F, 5'd0, 5'd13), PAT_C);
         issue("R7 ceq31",   mk(6'h07, 3'd0, 2'(df), 5'h1F, 5'd0, 5'd14), PAT_B);
         issue("R7 clts-16", mk(6'h07, 3'd2, 2'(df), 5'h10, 5'd0, 5'd15), PAT_A);
         issue("R7 cles15",  mk(6'h07, 3'd4, 2'(df), 5'h0F, 5'd0, 5'd16), PAT_A);
         issue("R8 cltu31",  mk(6'h07, 3'd3, 2'(df), 5'd31, 5'd0, 5'd17), PAT_B);
         issue("R8 cleu31",  mk(6'h07, 3'd5, 2'(df), 5'd31, 5'd0, 5'd18), PAT_B);
         issue("R8 cleu0",   mk(6'h07, 3'd5, 2'(df), 5'd0, 5'd0, 5'd19), PAT_C);
      end
   endtask

   task automatic t_ldi();
      logic [9:0] vals [4] = '{10'h200, 10'h1FF, 10'h000, 10'h3FF};
      for (int df = 0; df < 4; df++) begin
         foreach (vals[k]) begin
            issue("R9 ldi", mk(6'h07, 3'd6, 2'(df), vals[k][9:5], vals[k][4:0], 5'd20), PAT_A);
            issue("R9 ldi src", mk(6'h07, 3'd6, 2'(df), vals[k][9:5], vals[k][4:0], 5'd21), ~PAT_A);
         end
      end
   endtask

   task automatic t_reserved();
      issue("R2 R3 a6", mk(6'h06, 3'd6, 2'd0, 5'd3, 5'd0, 5'd22), PAT_A);
      issue("R2 R3 a7", mk(6'h06, 3'd7, 2'd1, 5'd3, 5'd0, 5'd23), PAT_A);
      issue("R2 R3 b1", mk(6'h07, 3'd1, 2'd2, 5'd3, 5'd0, 5'd24), PAT_A);
      issue("R2 R3 b7", mk(6'h07, 3'd7, 2'd3, 5'd3, 5'd0, 5'd25), PAT_A);
      issue("R3 minor", mk(6'h05, 3'd0, 2'd0, 5'd3, 5'd0, 5'd26), PAT_A);
   endtask

   task automatic t_stream();
      logic [31:0] i1, i2;
      logic [128:0] e1, e2;
      i1 = mk(6'h06, 3'd0, 2'd0, 5'd7, 5'd0, 5'd27);
      i2 = mk(6'h07, 3'd6, 2'd3, 5'd9, 5'd3, 5'd28);
      e1 = model(i1, PAT_A);
      e2 = model(i2, PAT_B);
      @(negedge clk);
      in_valid = 1'b1; instr = i1; src_vec = PAT_A;
      @(negedge clk);
      instr = i2; src_vec = PAT_B;
      check("R10 b2b first", out_vec, e1[127:0]);
      @(negedge clk);
      in_valid = 1'b0;
      check("R10 b2b second", out_vec, e2[127:0]);
      check("R1 b2b dst", 128'(out_dst), 128'd28);
      last_vec = e2[127:0];
      last_dst = 5'd28;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         check("R10 idle valid", 128'({out_valid, out_rsvd}), 128'd0);
         check("R10 idle vec", out_vec, last_vec);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_addsub();
      t_minmax();
      t_compare();
      t_ldi();
      t_reserved();
      t_stream();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule